// File: doc/BRIEF.md
# Timer-Driven Manchester / Pulse-Width Bit Decoder

This block recovers bytes from a self-clocked serial line. It synchronises the line into the clock domain and looks for transitions on it. A saturating bit timer measures the time since the last accepted transition. Each decoded bit is taken from the line at a programmed delay after a transition and shifted into an eight-bit register. After eight bits the assembled byte is presented with a one-cycle valid strobe.

Two codings are supported. In Manchester mode a transition of either polarity counts. The decoder stays in a hunting state until it measures a gap between two transitions at least as long as the sample delay. A full-bit gap passes that test and a half-bit gap does not, so the decoder locks onto a mid-bit transition. In pulse-width mode only rising transitions count. The first leading edge locks the decoder, and the line level at the sample delay gives the bit.

While the decoder waits for a transition after a sample, the timer is compared against a second, longer limit. If no transition arrives in time, the decoder raises a one-cycle error interrupt, drops any partly built byte and goes back to hunting. Software programs both compare values in clock cycles.

Top module: `bitclock_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rx_byte_o` is 0, `rx_valid_o` is 0 and `err_irq_o` is 0.
- R2: With `pw_mode_i`=0 both rising and falling transitions of the synchronised line are accepted. With `pw_mode_i`=1 only rising transitions are accepted, and falling ones change nothing.
- R3: In the hunting state, the decoder locks in Manchester mode on a transition whose timer value (clock cycles since the previous transition, minus one) is at least `cmp_sample_i`, and only if a previous transition was seen since hunting began. In pulse-width mode the first rising transition locks it. Every transition seen while hunting clears the timer.
- R4: Once locked, the synchronised line level is shifted in when the timer equals `cmp_sample_i`. Bits enter at the LSB and move toward the MSB, so the first decoded bit ends up as bit 7 of the byte.
- R5: Transitions between a resynchronising transition and the sample that follows it are ignored. The first accepted transition after a sample clears the timer and arms the next sample.
- R6: When the eighth bit is shifted in, the byte appears on `rx_byte_o` together with a one-cycle `rx_valid_o`. `rx_byte_o` holds its value at all other times.
- R7: In the wait-for-transition state, a timer value equal to `cmp_limit_i` with no accepted transition in that cycle gives a one-cycle `err_irq_o`, clears the bit count and returns the decoder to hunting. `cmp_limit_i` must exceed `cmp_sample_i`.
- R8: While `en_i` is 0 the decoder is held in hunting with the bit count and timer cleared, and it produces neither a valid strobe nor an error.
- R9: A Manchester stream that contains only half-bit gaps (a run of equal bits) never locks the decoder, so it produces no byte and no error.
- R10: The line passes two synchronising flops and one history flop. A line change can therefore affect decoder state no earlier than the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Serial coded line, asynchronous |
| pw_mode_i | input | 1 | 0 = Manchester, 1 = pulse-width |
| en_i | input | 1 | Decoder enable |
| cmp_sample_i | input | CNT_W | Timer value at which the line is sampled; also the minimum lock gap |
| cmp_limit_i | input | CNT_W | Timer value that flags a missing transition |
| rx_byte_o | output | BYTE_W | Last completed byte |
| rx_valid_o | output | 1 | One-cycle strobe when a byte completes |
| err_irq_o | output | 1 | One-cycle timing error interrupt |

## Verification
Manchester frames carrying 0xA5, 0x00, 0xFF and 0x3C each begin with a 0-then-1 preamble. Together they cover alternating bits, long runs that put a boundary transition inside every sample window, and runs of either level, which separates correct window masking from a decoder that resynchronises on every transition. A run of identical Manchester bits with only half-bit gaps must never lock. A frame sent while disabled must leave no trace. Pulse-width frames carrying 0xC3 and 0x5A include falling edges during the wait-for-transition window, so a decoder that accepts both polarities in that mode is exposed. Every cycle, a behavioural reference driven by the same stimulus predicts the three outputs, which pins down the synchroniser latency and the exact cycle of each strobe.

// File: rtl/bd_pkg.sv
package bd_pkg;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_AWAIT  = 2'd2
    } dec_state_e;

    typedef struct packed {
        dec_state_e state;
        logic       seen;
        logic       err;
    } dec_ctrl_t;

endpackage

// File: rtl/bd_line_edge.sv
module bd_line_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    input  logic rise_only_i,
    output logic level_o,
    output logic edge_o
);
    localparam int N = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

    typedef struct packed {
        logic [N-1:0] chain;
        logic         prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[N-2:0], line_i};
        st_d.prev  = st_q.chain[N-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.chain[N-1];
    assign edge_o  = rise_only_i ? (st_q.chain[N-1] & ~st_q.prev)
                                 : (st_q.chain[N-1] ^ st_q.prev);
endmodule

// File: rtl/bd_bit_timer.sv
module bd_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic [CNT_W-1:0] cmp_a_i,
    input  logic [CNT_W-1:0] cmp_b_i,
    output logic             hit_a_o,
    output logic             hit_b_o,
    output logic             reach_a_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clear_i) begin
            cnt_d = '0;
        end else if (&cnt_q) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit_a_o   = (cnt_q == cmp_a_i);
    assign hit_b_o   = (cnt_q == cmp_b_i);
    assign reach_a_o = (cnt_q >= cmp_a_i);
endmodule

// File: rtl/bd_byte_pack.sv
module bd_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              shift_i,
    input  logic              bit_i,
    input  logic              flush_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              valid_o
);
    localparam int SR_W = BYTE_W - 1;
    localparam int CW   = $clog2(BYTE_W);
    localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

    typedef struct packed {
        logic [SR_W-1:0]   sr;
        logic [CW-1:0]     cnt;
        logic [BYTE_W-1:0] data;
        logic              valid;
    } pack_st_t;

    pack_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (flush_i) begin
            st_d.cnt = '0;
        end else if (shift_i) begin
            if (st_q.cnt == LAST) begin
                st_d.data  = {st_q.sr, bit_i};
                st_d.valid = 1'b1;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            st_d.sr = {st_q.sr[SR_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_o  = st_q.data;
    assign valid_o = st_q.valid;
endmodule

// File: rtl/bitclock_decoder.sv
module bitclock_decoder #(
    parameter int CNT_W       = 8,
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              line_i,
    input  logic              pw_mode_i,
    input  logic              en_i,
    input  logic [CNT_W-1:0]  cmp_sample_i,
    input  logic [CNT_W-1:0]  cmp_limit_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              err_irq_o
);
    import bd_pkg::*;

    logic level, edge_hit;
    logic hit_a, hit_b, reach_a;
    logic tmr_clear, do_shift, do_flush;
    dec_ctrl_t ctl_d, ctl_q;
    dec_state_e cur_state;

    bd_line_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .line_i      (line_i),
        .rise_only_i (pw_mode_i),
        .level_o     (level),
        .edge_o      (edge_hit)
    );

    bd_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .clear_i   (tmr_clear),
        .cmp_a_i   (cmp_sample_i),
        .cmp_b_i   (cmp_limit_i),
        .hit_a_o   (hit_a),
        .hit_b_o   (hit_b),
        .reach_a_o (reach_a)
    );

    bd_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .shift_i (do_shift),
        .bit_i   (level),
        .flush_i (do_flush),
        .byte_o  (rx_byte_o),
        .valid_o (rx_valid_o)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        tmr_clear = 1'b0;
        do_shift  = 1'b0;
        do_flush  = 1'b0;
        if (!en_i) begin
            ctl_d.state = ST_HUNT;
            ctl_d.seen  = 1'b0;
            tmr_clear   = 1'b1;
            do_flush    = 1'b1;
        end else begin
            unique case (ctl_q.state)
                ST_HUNT: begin
                    if (edge_hit) begin
                        tmr_clear  = 1'b1;
                        ctl_d.seen = 1'b1;
                        if (pw_mode_i || (ctl_q.seen && reach_a)) begin
                            ctl_d.state = ST_SAMPLE;
                        end
                    end
                end
                ST_SAMPLE: begin
                    if (hit_a) begin
                        do_shift    = 1'b1;
                        ctl_d.state = ST_AWAIT;
                    end
                end
                ST_AWAIT: begin
                    if (edge_hit) begin
                        tmr_clear   = 1'b1;
                        ctl_d.state = ST_SAMPLE;
                    end else if (hit_b) begin
                        ctl_d.err   = 1'b1;
                        ctl_d.seen  = 1'b0;
                        ctl_d.state = ST_HUNT;
                        tmr_clear   = 1'b1;
                        do_flush    = 1'b1;
                    end
                end
                default: begin
                    ctl_d.state = ST_HUNT;
                    ctl_d.seen  = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{state: ST_HUNT, seen: 1'b0, err: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign err_irq_o = ctl_q.err;
    assign cur_state = ctl_q.state;
endmodule

// File: rtl/bd_dec_chk.sv
module bd_dec_chk #(
    parameter int BYTE_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               valid,
    input logic               err,
    input logic [BYTE_W-1:0]  data,
    input bd_pkg::dec_state_e state
);
    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
    // R6
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(data));
    // R7
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    // R7
    err_from_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(state) == bd_pkg::ST_AWAIT && state == bd_pkg::ST_HUNT));
    // R8
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!valid && !err && state == bd_pkg::ST_HUNT));
    // R6
    valid_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid && err));
endmodule

bind bitclock_decoder bd_dec_chk #(.BYTE_W(BYTE_W)) u_dec_chk (
    .clk   (clk_i),
    .rst_n (rst_ni),
    .en    (en_i),
    .valid (rx_valid_o),
    .err   (err_irq_o),
    .data  (rx_byte_o),
    .state (cur_state)
);

// File: tb/test_bitclock_decoder.sv
module test_bitclock_decoder;
    localparam int CW = 8;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          line = 1'b0;
    logic          pw = 1'b0;
    logic          en = 1'b0;
    logic [CW-1:0] c1 = 8'd12;
    logic [CW-1:0] c2 = 8'd24;
    logic [BW-1:0] rx_byte;
    logic          rx_valid, err_irq;

    int checks = 0;
    int errors = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [BW-1:0] got[$];

    always #5 clk = ~clk;

    bitclock_decoder #(.CNT_W(CW), .BYTE_W(BW)) i_bitclock_decoder (
        .clk_i(clk), .rst_ni(rst_n), .line_i(line), .pw_mode_i(pw), .en_i(en),
        .cmp_sample_i(c1), .cmp_limit_i(c2),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .err_irq_o(err_irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference: 0 hunt, 1 sample, 2 await
    int ms0, ms1, mp, mst, mseen, mtmr, mcnt, msr, mbyte, mvalid, merr;
    always @(posedge clk) begin
        if (!rst_n) begin
            ms0 = 0; ms1 = 0; mp = 0; mst = 0; mseen = 0; mtmr = 0;
            mcnt = 0; msr = 0; mbyte = 0; mvalid = 0; merr = 0;
        end else begin
            int e;
            int t_old;
            e = pw ? (ms1 == 1 && mp == 0) : (ms1 != mp);
            t_old = mtmr;
            mvalid = 0;
            merr = 0;
            if (!en) begin
                mst = 0; mseen = 0; mtmr = 0; mcnt = 0;
            end else if (mst == 0) begin
                if (e != 0) begin
                    if (pw || (mseen == 1 && t_old >= int'(c1))) mst = 1;
                    mseen = 1;
                    mtmr = 0;
                end else if (mtmr < 255) mtmr++;
            end else if (mst == 1) begin
                if (t_old == int'(c1)) begin
                    msr = ((msr << 1) | ms1) & 255;
                    mcnt++;
                    if (mcnt == 8) begin mbyte = msr; mvalid = 1; mcnt = 0; end
                    mst = 2;
                end
                if (mtmr < 255) mtmr++;
            end else begin
                if (e != 0) begin
                    mst = 1; mtmr = 0;
                end else if (t_old == int'(c2)) begin
                    merr = 1; mcnt = 0; mst = 0; mseen = 0; mtmr = 0;
                end else if (mtmr < 255) mtmr++;
            end
            mp = ms1; ms1 = ms0; ms0 = int'(line);
        end
    end

    // R10 cycle compare against reference (captures synchroniser latency)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(int'(rx_valid) == mvalid, "R10 valid vs reference", int'(rx_valid), mvalid);
            check(int'(err_irq) == merr, "R10 err vs reference", int'(err_irq), merr);
            check(int'(rx_byte) == mbyte, "R10 byte vs reference", int'(rx_byte), mbyte);
            if (rx_valid) got.push_back(rx_byte);
            if (err_irq) n_err++;
        end
    end

    task automatic man_bit(input logic b);
        line = b;
        repeat (8) @(negedge clk);
        line = ~b;
        repeat (8) @(negedge clk);
    endtask

    task automatic man_send(input logic [7:0] d);
        got.delete();
        n_err = 0;
        man_bit(1'b0);
        man_bit(1'b1);
        for (int i = 7; i >= 0; i--) man_bit(d[i]);
        repeat (60) @(negedge clk);
    endtask

    task automatic pw_send(input logic [7:0] d);
        got.delete();
        n_err = 0;
        for (int i = 7; i >= 0; i--) begin
            line = 1'b1;
            repeat (d[i] ? 12 : 4) @(negedge clk);
            line = 1'b0;
            repeat (d[i] ? 4 : 12) @(negedge clk);
        end
        repeat (60) @(negedge clk);
    endtask

    task automatic frame_checks(input logic [7:0] d, input string tag);
        check(got.size() == 1, {tag, " one byte per frame (R6)"}, got.size(), 1);
        if (got.size() > 0)
            check(got[0] == d, {tag, " decoded byte (R4 R5)"}, int'(got[0]), int'(d));
        check(n_err == 1, {tag, " one timeout after frame (R7)"}, n_err, 1);
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        // R1 reset state
        check(rx_byte == '0 && !rx_valid && !err_irq, "R1 outputs in reset",
              int'(rx_byte) + int'(rx_valid) + int'(err_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_byte == '0 && !rx_valid && !err_irq, "R1 outputs after reset",
              int'(rx_byte) + int'(rx_valid) + int'(err_irq), 0);
        en = 1'b1;
        repeat (20) @(negedge clk);

        // R2 R3 Manchester, both polarities, lock on full-bit gap
        man_send(8'hA5); frame_checks(8'hA5, "R2 R3 man A5");
        man_send(8'h00); frame_checks(8'h00, "R5 man 00");

        // R9 half-bit gaps only
        got.delete(); n_err = 0;
        repeat (20) man_bit(1'b0);
        repeat (40) @(negedge clk);
        check(got.size() == 0, "R9 no byte from half-bit stream", got.size(), 0);
        check(n_err == 0, "R9 no error from half-bit stream", n_err, 0);

        // R8 disabled
        en = 1'b0;
        man_send(8'h96);
        check(got.size() == 0, "R8 no byte while disabled", got.size(), 0);
        check(n_err == 0, "R8 no error while disabled", n_err, 0);
        en = 1'b1;
        repeat (20) @(negedge clk);

        man_send(8'hFF); frame_checks(8'hFF, "R4 man FF");
        man_send(8'h3C); frame_checks(8'h3C, "R6 man 3C");

        // R2 R3 pulse-width: rising edges only
        pw = 1'b1; c1 = 8'd8; c2 = 8'd24; line = 1'b0;
        repeat (40) @(negedge clk);
        pw_send(8'hC3); frame_checks(8'hC3, "R2 R3 pw C3");
        pw_send(8'h5A); frame_checks(8'h5A, "R2 pw 5A");
        check(rx_byte == 8'h5A, "R6 byte held after strobe", int'(rx_byte), 'h5A);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired actual=1 expected=0");
            end
        join_any
        disable fork;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule